// File: doc/BRIEF.md
# Parity-Capable Serial Word Transmitter

This block takes 32-bit words from a 16-bit host bus, queues them, and sends each one as a serial bit stream. The host gives each word in two strobes: first the low half, then the high half. The two halves are joined into one word, and the word goes into a 32-entry first-in first-out queue. If the queue is full, the load is dropped. The host can track the queue through three flags: empty, below half, and full.

A serializer takes the oldest queued word and sends it one bit per bit-clock enable, least significant bit first. It does this only while transmission is enabled. A control bit decides what the last of the 32 bits carries. It is either the loaded data bit or a generated parity bit, and a second control bit picks odd or even parity. Between two words the serializer sends at least four null bit periods. It also reports null whenever it has nothing to send. The enable pulse is generated outside this block from a reference clock through a divider.

Top module: `sertx_top`

## Requirements
- R1: A strobe on `ld_lo` captures `host_data` as bits 15:0. A following strobe on `ld_hi` captures `host_data` as bits 31:16, and the joined word is appended to the queue. Words are sent in the order they were loaded.
- R2: A strobe on `ld_hi` with no `ld_lo` since the last `ld_hi` is ignored and queues nothing.
- R3: The queue holds 32 words. `fifo_full` is high exactly when 32 words are queued. A load completed while the queue is full is discarded, and the queue contents stay unchanged.
- R4: `half_low` is high exactly while fewer than 16 words are queued.
- R5: `tx_ready` is high exactly while the queue is empty. No word starts while it is high.
- R6: A word starts on a `bit_tick` cycle. From the next clock, `ser_null` is low and `ser_bit` shows word bit 0. Each later `bit_tick` moves to the next bit, bit 0 first and bit 31 last. The output changes only on `bit_tick` cycles.
- R7: If `par_en` is 1 when a word starts, bit 31 is replaced by parity over bits 30:0. With `par_even` = 0 the 32 sent bits hold an odd number of ones; with `par_even` = 1 they hold an even number.
- R8: If `par_en` is 0 when a word starts, all 32 loaded bits are sent unchanged.
- R9: While no word is being sent, `ser_null` is 1 and `ser_bit` is 0. After the bit tick that ends bit 31, at least four whole bit periods pass before the next word starts.
- R10: While `tx_en` is 0, no new word starts. A word already in progress runs to its end.
- R11: After reset the queue is empty, `ser_null` is 1, `ser_bit` is 0, `tx_ready` is 1, `half_low` is 1, and `fifo_full` is 0. A word may start on the first eligible bit tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle bit-clock enable |
| ld_lo | input | 1 | Strobe that captures the low half of a word |
| ld_hi | input | 1 | Strobe that captures the high half and completes the word |
| host_data | input | 16 | Host data bus |
| tx_en | input | 1 | Allows new words to start |
| par_en | input | 1 | 1: bit 31 carries parity; 0: bit 31 carries data |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| ser_bit | output | 1 | Serial data bit |
| ser_null | output | 1 | High while the line is null |
| tx_ready | output | 1 | High while the queue is empty |
| half_low | output | 1 | High while fewer than 16 words are queued |
| fifo_full | output | 1 | High while 32 words are queued |

## Verification
The hardest case to reach is a load completed against a full queue while the serializer sits idle. If the bench waits too long, the queue drains before the extra load arrives. The stimulus avoids this by holding `tx_en` low, loading 34 words, and only then enabling transmission, so the two extra loads reach a queue known to be full. The reference model tracks the queue, and its order then shows that those two loads were dropped. Parity sense and parity enable are switched while words are in flight, and `tx_en` is dropped in the middle of a word. This shows that both controls are sampled only at word start and that a word in progress finishes.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic {
        TX_NULL = 1'b0,
        TX_DATA = 1'b1
    } tx_state_e;

    // xor_sum is the XOR of the protected bits; returns the bit that
    // gives an even (even_sel=1) or odd (even_sel=0) count of ones.
    function automatic logic gen_parity(input logic xor_sum, input logic even_sel);
        return even_sel ? xor_sum : ~xor_sum;
    endfunction

endpackage

// File: rtl/sertx_loader.sv
module sertx_loader #(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_lo,
    input  logic                  ld_hi,
    input  logic [HALF_W-1:0]     host_data,
    output logic                  push,
    output logic [2*HALF_W-1:0]   push_word
);

    typedef struct packed {
        logic              pend;
        logic [HALF_W-1:0] lo;
    } ld_state_t;

    ld_state_t st_d, st_q;

    // a high-half strobe only completes a word when a low half is pending
    assign push      = ld_hi && st_q.pend;
    assign push_word = {host_data, st_q.lo};

    always_comb begin
        st_d = st_q;
        if (ld_hi) begin
            st_d.pend = 1'b0;
        end
        if (ld_lo) begin
            st_d.pend = 1'b1;
            st_d.lo   = host_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic [CW-1:0]     fill,
    output logic              empty,
    output logic              full,
    output logic              below_half
);

    localparam int HALF = DEPTH / 2;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } q_state_t;

    q_state_t st_d, st_q;
    logic [WORD_W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full       = (st_q.cnt == CW'(DEPTH));
    assign empty      = (st_q.cnt == '0);
    assign below_half = (st_q.cnt < CW'(HALF));
    assign fill       = st_q.cnt;
    assign head       = mem[st_q.rd];

    // fullness judged before any same-cycle pop
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.wr = wrap_inc(st_q.wr);
        end
        if (pop_ok) begin
            st_d.rd = wrap_inc(st_q.rd);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[st_q.wr] <= push_word;
        end
    end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int GAP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] head,
    output logic              pop,
    output logic              ser_bit,
    output logic              ser_null
);

    localparam int IW = $clog2(WORD_W);
    localparam int GW = $clog2(GAP_BITS + 1);

    typedef struct packed {
        tx_state_e     st;
        logic [WORD_W-1:0] sh;
        logic [IW-1:0] idx;
        logic [GW-1:0] gap;
    } sh_state_t;

    sh_state_t st_d, st_q;
    logic [WORD_W-1:0] load_word;
    logic              gap_done;

    assign gap_done = (st_q.gap == GW'(GAP_BITS));
    assign pop      = bit_tick && (st_q.st == TX_NULL) && gap_done && tx_en && !fifo_empty;

    always_comb begin
        load_word = head;
        if (par_en) begin
            load_word[WORD_W-1] = gen_parity(^head[WORD_W-2:0], par_even);
        end
    end

    assign ser_null = (st_q.st == TX_NULL);
    assign ser_bit  = (st_q.st == TX_DATA) && st_q.sh[0];

    always_comb begin
        st_d = st_q;
        if (pop) begin
            st_d.st  = TX_DATA;
            st_d.sh  = load_word;
            st_d.idx = '0;
        end else if (st_q.st == TX_DATA && bit_tick) begin
            if (st_q.idx == IW'(WORD_W - 1)) begin
                st_d.st  = TX_NULL;
                st_d.gap = GW'(1);
            end else begin
                st_d.sh  = st_q.sh >> 1;
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (st_q.st == TX_NULL && bit_tick && !gap_done) begin
            st_d.gap = st_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.st  <= TX_NULL;
            st_q.sh  <= '0;
            st_q.idx <= '0;
            st_q.gap <= GW'(GAP_BITS);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int HALF_W   = 16,
    parameter int DEPTH    = 32,
    parameter int GAP_BITS = 4,
    localparam int WORD_W  = 2 * HALF_W,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [HALF_W-1:0] host_data,
    input  logic              tx_en,
    input  logic              par_en,
    input  logic              par_even,
    output logic              ser_bit,
    output logic              ser_null,
    output logic              tx_ready,
    output logic              half_low,
    output logic              fifo_full
);

    logic              push;
    logic [WORD_W-1:0] push_word;
    logic              pop;
    logic [WORD_W-1:0] head;
    logic [CW-1:0]     fill;
    logic              empty;

    sertx_loader #(.HALF_W(HALF_W)) i_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_lo     (ld_lo),
        .ld_hi     (ld_hi),
        .host_data (host_data),
        .push      (push),
        .push_word (push_word)
    );

    sertx_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_word  (push_word),
        .pop        (pop),
        .head       (head),
        .fill       (fill),
        .empty      (empty),
        .full       (fifo_full),
        .below_half (half_low)
    );

    sertx_shift #(.WORD_W(WORD_W), .GAP_BITS(GAP_BITS)) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .tx_en      (tx_en),
        .par_en     (par_en),
        .par_even   (par_even),
        .fifo_empty (empty),
        .head       (head),
        .pop        (pop),
        .ser_bit    (ser_bit),
        .ser_null   (ser_null)
    );

    assign tx_ready = empty;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_tick,
    input logic          tx_en,
    input logic          pop,
    input logic [CW-1:0] fill,
    input logic          ser_bit,
    input logic          ser_null,
    input logic          tx_ready,
    input logic          half_low,
    input logic          fifo_full
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH)); // R3

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CW'(DEPTH) && !pop) |=> (fill == CW'(DEPTH))); // R3

    AST_FULL_NOT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !half_low); // R4

    AST_NO_START_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !tx_ready); // R5

    AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> ($stable(ser_bit) && $stable(ser_null))); // R6

    AST_NULL_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ser_null |-> !ser_bit); // R9

    AST_GAP_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_null) |=> ser_null); // R9

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && ser_null) |=> ser_null); // R10

endmodule

bind sertx_top sertx_chk #(.DEPTH(DEPTH), .CW(CW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .tx_en     (tx_en),
    .pop       (pop),
    .fill      (fill),
    .ser_bit   (ser_bit),
    .ser_null  (ser_null),
    .tx_ready  (tx_ready),
    .half_low  (half_low),
    .fifo_full (fifo_full)
);

// File: tb/test_sertx_top.sv
`timescale 1ns/1ps
module test_sertx_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        ld_lo = 1'b0;
    logic        ld_hi = 1'b0;
    logic [15:0] host_data = '0;
    logic        tx_en = 1'b0;
    logic        par_en = 1'b0;
    logic        par_even = 1'b0;
    logic        ser_bit, ser_null, tx_ready, half_low, fifo_full;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int tdiv = 3;
    int tcnt = 0;
    bit run = 1'b0;

    sertx_top i_sertx_top (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .host_data(host_data), .tx_en(tx_en), .par_en(par_en), .par_even(par_even),
        .ser_bit(ser_bit), .ser_null(ser_null), .tx_ready(tx_ready),
        .half_low(half_low), .fifo_full(fifo_full)
    );

    always #5 clk = ~clk;

    // reference model
    logic [31:0] m_q[$];
    bit          m_pend, m_send, m_par;
    logic [15:0] m_lo;
    logic [31:0] m_sh, m_w;
    int          m_idx, m_gap, m_sz;
    bit          m_start;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete(); m_pend = 0; m_send = 0; m_par = 0;
            m_lo = '0; m_sh = '0; m_idx = 0; m_gap = 4;
        end else begin
            m_sz = m_q.size();
            m_start = bit_tick && !m_send && m_gap >= 4 && tx_en && m_sz > 0;
            if (m_start) begin
                m_w = m_q.pop_front();
                if (par_en) m_w[31] = par_even ? ^m_w[30:0] : ~^m_w[30:0];
                m_sh = m_w; m_send = 1; m_idx = 0; m_par = par_en;
            end else if (m_send && bit_tick) begin
                if (m_idx == 31) begin m_send = 0; m_gap = 1; end
                else begin m_sh = m_sh >> 1; m_idx++; end
            end else if (!m_send && bit_tick && m_gap < 4) begin
                m_gap++;
            end
            if (ld_hi && m_pend && m_sz < 32) m_q.push_back({host_data, m_lo});
            if (ld_hi) m_pend = 0;
            if (ld_lo) begin m_pend = 1; m_lo = host_data; end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && run) begin
            chk(tx_ready,  m_q.size() == 0,  "R5 tx_ready");
            chk(half_low,  m_q.size() < 16,  "R4 half_low");
            chk(fifo_full, m_q.size() == 32, "R3 fifo_full");
            chk(ser_null,  !m_send,          "R9 ser_null");
            if (!m_send)               chk(ser_bit, 1'b0,    "R9 idle ser_bit");
            else if (m_idx == 31 && m_par)  chk(ser_bit, m_sh[0], "R7 parity bit");
            else if (m_idx == 31)      chk(ser_bit, m_sh[0], "R8 data bit 32");
            else                       chk(ser_bit, m_sh[0], "R6 serial bit");
        end
    end

    always @(negedge clk) begin
        if (tcnt >= tdiv - 1) begin tcnt <= 0; bit_tick <= 1'b1; end
        else begin tcnt <= tcnt + 1; bit_tick <= 1'b0; end
    end

    task automatic final_report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            final_report();
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic load(input logic [31:0] w);
        @(negedge clk); #1; ld_lo = 1'b1; host_data = w[15:0];
        @(negedge clk); #1; ld_lo = 1'b0; ld_hi = 1'b1; host_data = w[31:16];
        @(negedge clk); #1; ld_hi = 1'b0; host_data = '0;
    endtask

    initial begin
        step(5);
        // R11 reset state
        chk(ser_null, 1'b1, "R11 reset ser_null");
        chk(ser_bit, 1'b0, "R11 reset ser_bit");
        chk(tx_ready, 1'b1, "R11 reset tx_ready");
        chk(half_low, 1'b1, "R11 reset half_low");
        chk(fifo_full, 1'b0, "R11 reset fifo_full");
        rst_n = 1'b1; run = 1'b1;
        step(2);

        // R2 orphan high strobe
        ld_hi = 1'b1; host_data = 16'hBEEF; step(1); ld_hi = 1'b0; step(2);
        chk(tx_ready, 1'b1, "R2 orphan high strobe queued nothing");

        // R1/R3/R4 fill with transmission held off (R10)
        for (int i = 0; i < 34; i++) begin
            load(32'h8000_0001 ^ (i * 32'h0137_9B2D));
            step(1);
            if (i == 14) chk(half_low, 1'b1, "R4 15 queued");
            if (i == 15) chk(half_low, 1'b0, "R4 16 queued");
            if (i == 31) chk(fifo_full, 1'b1, "R3 32 queued");
        end
        chk(fifo_full, 1'b1, "R3 loads while full dropped");
        chk(ser_null, 1'b1, "R10 no start while disabled");

        // R1 R6 R8 plain data, then disable mid-word (R10)
        par_en = 1'b0; tx_en = 1'b1;
        step(400);
        tx_en = 1'b0;
        step(300);
        // R7 odd parity, change sense mid-word
        tx_en = 1'b1; par_en = 1'b1; par_even = 1'b0;
        step(700);
        par_even = 1'b1;
        step(500);
        load(32'h7FFF_FFFF);
        load(32'h0000_0000);
        par_en = 1'b0;
        step(600);
        // fast ticks: gap of 4 at one clock per bit
        tdiv = 1;
        load(32'hFFFF_FFFF);
        load(32'h1234_5678);
        par_en = 1'b1;
        wait (m_q.size() == 0 && !m_send);
        step(20);
        chk(tx_ready, 1'b1, "R5 drained");
        chk(ser_null, 1'b1, "R9 idle after drain");
        run = 1'b0;
        final_report();
    end

endmodule